// File: doc/BRIEF.md
# Receive FIFO Availability Flag Generator

This block sits between four receive FIFOs and a shared PHY-to-link-layer receive bus. Each cycle it looks at every FIFO's word occupancy and at its count of stored end-of-frame markers. It compares the occupancy with a programmable watermark and raises a registered "data available" flag for each channel. A configuration bit selects whether stored end-of-frame markers also raise the flag, or whether only the watermark counts.

The flags can be presented in two ways. In direct mode they are enabled all the time. In polled mode their enable follows a match between the upper bits of the receive address bus and a programmed 3-bit base address, seen one cycle later on the lighter bus variant and two cycles later on the heavier one. A shared-bus setting restricts the data, start-of-cell, parity and flag enables to the cycles in which this device is selected. It also restricts the polled packet-available output to addresses that carry this device's base.

Each output comes with its own enable, which models a tri-state pin.

Top module: `rx_avail_flags`

## Requirements
- R1: Four channel flags `avail_o[c]`, c = 0..3, are registered. Each depends only on channel c's occupancy (`occ_i[16c+15:16c]`) and end-of-frame count (`eofcnt_i[6c+5:6c]`), sampled at the previous rising edge.
- R2: With the end-of-frame ignore bit clear, a channel flag is 1 one cycle after its end-of-frame count is nonzero.
- R3: A channel flag is 1 one cycle after its occupancy is greater than or equal to the watermark. This includes equality, and holds in both end-of-frame settings. Otherwise, with no end-of-frame contribution, it is 0.
- R4: With the end-of-frame ignore bit set, the end-of-frame count has no effect on any flag.
- R5: With the direct bit set and the shared bit clear, `avail_oe_o` is 1 in every cycle.
- R6: With the direct bit clear and `bus_l3_i` = 0, `avail_oe_o` follows whether `rx_addr_i[4:2]` equalled the base address at the previous edge, gated by the shared-bus rule. A non-match removes the enable with the same one-cycle latency.
- R7: With the direct bit clear and `bus_l3_i` = 1, the same match condition takes effect two edges later.
- R8: With the shared bit set, `dat_oe_o`, `sop_oe_o`, `prty_oe_o` and `avail_oe_o` are 0 whenever `rx_sel_i` is 0.
- R9: `pfa_o` equals the flag of the channel named by `rx_addr_i[1:0]`. `pfa_oe_o` is 1 in single-device mode; in shared mode it is 1 only while `rx_addr_i[4:2]` equals the base address.
- R10: With the shared bit clear, `dat_oe_o`, `sop_oe_o` and `prty_oe_o` are 1 in every cycle.
- R11: After reset the configuration is: ignore = 0, direct = 1, shared = 0, base = 0, watermark = 16'hFFFF. The flags and the match pipeline are 0.
- R12: A write (`cfg_we_i` = 1) loads all configuration fields at the rising edge. Flags computed at that same edge still use the previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_eof_ign_i | input | 1 | 1: end-of-frame markers do not raise flags |
| cfg_direct_i | input | 1 | 1: direct flag presentation, 0: polled |
| cfg_shared_i | input | 1 | 1: shared bus, enables gated by selection |
| cfg_base_i | input | 3 | Device base address |
| cfg_wmark_i | input | 16 | Receive watermark for all channels |
| bus_l3_i | input | 1 | 0: one-cycle poll latency, 1: two-cycle |
| occ_i | input | 64 | Four 16-bit FIFO occupancies |
| eofcnt_i | input | 24 | Four 6-bit stored end-of-frame counts |
| rx_addr_i | input | 5 | Receive address: [4:2] device, [1:0] channel |
| rx_sel_i | input | 1 | Device selected for a receive transfer |
| avail_o | output | 4 | Channel availability flags |
| avail_oe_o | output | 1 | Enable for the flag outputs |
| dat_oe_o | output | 1 | Enable for receive data |
| sop_oe_o | output | 1 | Enable for start-of-cell |
| prty_oe_o | output | 1 | Enable for parity |
| pfa_o | output | 1 | Polled availability of the addressed channel |
| pfa_oe_o | output | 1 | Enable for the polled availability output |

## Verification
Some properties are checked on every cycle: the per-channel flag rules for markers, watermark and ignore, the one- and two-cycle latency of the address match, and the enable gating in direct, shared and single-device modes. The bench's scenarios are needed for the rest: the reset values of the configuration, the exact watermark equality boundary, the point at which a configuration write takes effect, the choice of channel by the polled output, and the withdrawal of the enable after a non-matching address. A behavioural model compares every output against the design on each cycle to cover these.

// File: rtl/rx_avail_pkg.sv
package rx_avail_pkg;
  // Availability rule: watermark reached, or any stored marker when not ignored.
  function automatic logic avail_calc(input logic [31:0] occ,
                                      input logic [31:0] eofc,
                                      input logic [31:0] wmark,
                                      input logic        ign);
    return (occ >= wmark) || (!ign && (eofc != 32'd0));
  endfunction
endpackage

// File: rtl/rx_avail_cfg.sv
module rx_avail_cfg #(
  parameter int OCC_W  = 16,
  parameter int BASE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              eof_ign_i,
  input  logic              direct_i,
  input  logic              shared_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [OCC_W-1:0]  wmark_i,
  output logic              eof_ign_q,
  output logic              direct_q,
  output logic              shared_q,
  output logic [BASE_W-1:0] base_q,
  output logic [OCC_W-1:0]  wmark_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_ign_q <= 1'b0;
      direct_q  <= 1'b1;
      shared_q  <= 1'b0;
      base_q    <= '0;
      wmark_q   <= '1;
    end else if (we_i) begin
      eof_ign_q <= eof_ign_i;
      direct_q  <= direct_i;
      shared_q  <= shared_i;
      base_q    <= base_i;
      wmark_q   <= wmark_i;
    end
  end
endmodule

// File: rtl/rx_avail_chan.sv
module rx_avail_chan #(
  parameter int OCC_W = 16,
  parameter int EOF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [EOF_W-1:0] eofc_i,
  input  logic [OCC_W-1:0] wmark_i,
  input  logic             ign_i,
  output logic             flag_q
);
  import rx_avail_pkg::*;

  logic flag_d;
  assign flag_d = avail_calc(32'(occ_i), 32'(eofc_i), 32'(wmark_i), ign_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  p_eof_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eofc_i != '0 && !ign_i) |=> flag_q);
  p_wm_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_i >= wmark_i) |=> flag_q);
  p_ign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_i && occ_i < wmark_i) |=> !flag_q);
endmodule

// File: rtl/rx_avail_poll.sv
module rx_avail_poll #(
  parameter int BASE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] dev_addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              l3_i,
  output logic              hit_o,
  output logic              match_o
);
  logic m1_q, m2_q;

  assign hit_o = (dev_addr_i == base_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= 1'b0;
      m2_q <= 1'b0;
    end else begin
      m1_q <= hit_o;
      m2_q <= m1_q;
    end
  end

  generate
    if (1) begin : g_sel
      assign match_o = l3_i ? m2_q : m1_q;
    end
  endgenerate

  p_l2_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l3_i && hit_o) |=> (l3_i || match_o));
  p_l2_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l3_i && !hit_o) |=> (l3_i || !match_o));
  p_l3_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (l3_i && hit_o) |=> ##1 (!l3_i || match_o));
endmodule

// File: rtl/rx_avail_flags.sv
module rx_avail_flags #(
  parameter int N_CH   = 4,
  parameter int OCC_W  = 16,
  parameter int EOF_W  = 6,
  parameter int BASE_W = 3,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = BASE_W + CH_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we_i,
  input  logic                  cfg_eof_ign_i,
  input  logic                  cfg_direct_i,
  input  logic                  cfg_shared_i,
  input  logic [BASE_W-1:0]     cfg_base_i,
  input  logic [OCC_W-1:0]      cfg_wmark_i,
  input  logic                  bus_l3_i,
  input  logic [N_CH*OCC_W-1:0] occ_i,
  input  logic [N_CH*EOF_W-1:0] eofcnt_i,
  input  logic [ADDR_W-1:0]     rx_addr_i,
  input  logic                  rx_sel_i,
  output logic [N_CH-1:0]       avail_o,
  output logic                  avail_oe_o,
  output logic                  dat_oe_o,
  output logic                  sop_oe_o,
  output logic                  prty_oe_o,
  output logic                  pfa_o,
  output logic                  pfa_oe_o
);
  logic              eof_ign_q, direct_q, shared_q;
  logic [BASE_W-1:0] base_q;
  logic [OCC_W-1:0]  wmark_q;
  logic              addr_hit, poll_match, bus_grant;

  rx_avail_cfg #(.OCC_W(OCC_W), .BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i),
    .eof_ign_i(cfg_eof_ign_i), .direct_i(cfg_direct_i), .shared_i(cfg_shared_i),
    .base_i(cfg_base_i), .wmark_i(cfg_wmark_i),
    .eof_ign_q(eof_ign_q), .direct_q(direct_q), .shared_q(shared_q),
    .base_q(base_q), .wmark_q(wmark_q)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    rx_avail_chan #(.OCC_W(OCC_W), .EOF_W(EOF_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .occ_i(occ_i[c*OCC_W +: OCC_W]),
      .eofc_i(eofcnt_i[c*EOF_W +: EOF_W]),
      .wmark_i(wmark_q), .ign_i(eof_ign_q),
      .flag_q(avail_o[c])
    );
  end

  rx_avail_poll #(.BASE_W(BASE_W)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .dev_addr_i(rx_addr_i[ADDR_W-1:CH_W]), .base_i(base_q),
    .l3_i(bus_l3_i), .hit_o(addr_hit), .match_o(poll_match)
  );

  assign bus_grant  = !shared_q || rx_sel_i;
  assign dat_oe_o   = bus_grant;
  assign sop_oe_o   = bus_grant;
  assign prty_oe_o  = bus_grant;
  assign avail_oe_o = (direct_q || poll_match) && bus_grant;
  assign pfa_o      = avail_o[rx_addr_i[CH_W-1:0]];
  assign pfa_oe_o   = !shared_q || addr_hit;

  p_direct_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_q && !shared_q) |-> avail_oe_o);
  p_shared_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_q && !rx_sel_i) |-> !(dat_oe_o || sop_oe_o || prty_oe_o || avail_oe_o));
  p_single_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shared_q |-> (dat_oe_o && sop_oe_o && prty_oe_o && pfa_oe_o));
  p_pfa_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfa_o == avail_o[rx_addr_i[CH_W-1:0]]);
endmodule

// File: tb/rx_avail_flags_tb.sv
module rx_avail_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_ign = 0, cfg_dir = 1, cfg_shr = 0, l3 = 0, rx_sel = 0;
  logic [2:0]  cfg_base = 0;
  logic [15:0] cfg_wm = 16'hFFFF;
  logic [4:0]  rx_addr = 0;
  logic [15:0] occ [4];
  logic [5:0]  eofc [4];
  logic [63:0] occ_bus;
  logic [23:0] eof_bus;
  logic [3:0]  avail;
  logic avail_oe, dat_oe, sop_oe, prty_oe, pfa, pfa_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  for (genvar c = 0; c < 4; c++) begin : g_pack
    assign occ_bus[c*16 +: 16] = occ[c];
    assign eof_bus[c*6 +: 6]   = eofc[c];
  end

  rx_avail_flags dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_eof_ign_i(cfg_ign),
    .cfg_direct_i(cfg_dir), .cfg_shared_i(cfg_shr), .cfg_base_i(cfg_base),
    .cfg_wmark_i(cfg_wm), .bus_l3_i(l3), .occ_i(occ_bus), .eofcnt_i(eof_bus),
    .rx_addr_i(rx_addr), .rx_sel_i(rx_sel), .avail_o(avail), .avail_oe_o(avail_oe),
    .dat_oe_o(dat_oe), .sop_oe_o(sop_oe), .prty_oe_o(prty_oe),
    .pfa_o(pfa), .pfa_oe_o(pfa_oe)
  );

  // Behavioural reference state (R11 reset values, R12 write timing)
  bit m_ign, m_dir, m_shr;
  int m_base, m_wm;
  bit m_flag [4];
  bit m_hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ign <= 0; m_dir <= 1; m_shr <= 0; m_base <= 0; m_wm <= 65535;
      for (int c = 0; c < 4; c++) m_flag[c] <= 0;
      m_hist = {0, 0};
    end else begin
      for (int c = 0; c < 4; c++)
        m_flag[c] <= (int'(occ[c]) >= m_wm) || (!m_ign && int'(eofc[c]) > 0);
      m_hist.push_front(int'(rx_addr) / 4 == m_base);
      void'(m_hist.pop_back());
      if (cfg_we) begin
        m_ign <= cfg_ign; m_dir <= cfg_dir; m_shr <= cfg_shr;
        m_base <= int'(cfg_base); m_wm <= int'(cfg_wm);
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit grant, match;
    grant = !m_shr || rx_sel;
    match = l3 ? m_hist[1] : m_hist[0];
    for (int c = 0; c < 4; c++) chk("R1", $sformatf("avail[%0d]", c), avail[c], m_flag[c]);
    chk(m_dir ? "R5" : (l3 ? "R7" : "R6"), "avail_oe", avail_oe, (m_dir || match) && grant);
    chk(m_shr ? "R8" : "R10", "dat_oe", dat_oe, grant);
    chk(m_shr ? "R8" : "R10", "sop_oe", sop_oe, grant);
    chk(m_shr ? "R8" : "R10", "prty_oe", prty_oe, grant);
    chk("R9", "pfa", pfa, m_flag[rx_addr % 4]);
    chk("R9", "pfa_oe", pfa_oe, !m_shr || (int'(rx_addr) / 4 == m_base));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(bit ign, bit dir, bit shr, int base, int wm);
    @(negedge clk);
    cfg_ign = ign; cfg_dir = dir; cfg_shr = shr; cfg_base = 3'(base); cfg_wm = 16'(wm);
    cfg_we = 1;
    step();
    cfg_we = 0;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin occ[c] = 0; eofc[c] = 0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "avail reset", avail, 0);
    chk("R11", "avail_oe reset (direct)", avail_oe, 1);
    chk("R11", "dat_oe reset (single)", dat_oe, 1);
    rst_n = 1;
    step(2);
    // R2, R1: marker on channel 1 only, default watermark
    eofc[1] = 1; step(2);
    chk("R2", "ch1 flag from marker", avail[1], 1);
    chk("R1", "ch0 untouched", avail[0], 0);
    // R3 and R12: watermark 100, equality boundary
    wr(0, 1, 0, 0, 100);
    occ[0] = 99; occ[2] = 100; occ[3] = 101; step(2);
    chk("R3", "ch2 equal watermark", avail[2], 1);
    chk("R3", "ch0 below watermark", avail[0], 0);
    // R4: ignore markers
    wr(1, 1, 0, 0, 100);
    eofc[1] = 5; occ[1] = 0; step(2);
    chk("R4", "ch1 marker ignored", avail[1], 0);
    // R6: polled, one-cycle latency, base 5
    wr(1, 0, 0, 5, 100);
    l3 = 0;
    for (int k = 0; k < 12; k++) begin
      rx_addr = 5'((k % 3 == 0) ? (5 * 4 + k % 4) : (2 * 4 + k % 4));
      step();
    end
    // R7: two-cycle latency
    l3 = 1;
    step(2);
    for (int k = 0; k < 12; k++) begin
      rx_addr = 5'((k % 4 < 2) ? (5 * 4 + k % 4) : (1 * 4 + k % 4));
      step();
    end
    // R8, R9, R10: shared bus with selection toggling
    l3 = 0;
    wr(0, 1, 1, 5, 100);
    for (int k = 0; k < 16; k++) begin
      rx_sel = k[0];
      rx_addr = 5'((k[1] ? 5 : 3) * 4 + k % 4);
      occ[k % 4] = 16'(90 + 3 * k);
      step();
    end
    rx_sel = 0; step();
    chk("R8", "dat_oe off when not selected", dat_oe, 0);
    // back to single device, polled (R10, R6)
    wr(0, 0, 0, 2, 95);
    for (int k = 0; k < 10; k++) begin
      rx_addr = 5'((k[0] ? 2 : 6) * 4 + k % 4);
      step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule